// File: doc/BRIEF.md
# Serial Configuration Command Receiver

This block takes configuration words from a host over a three-wire, write-only serial port made of a frame enable, a serial clock and a serial data line. It samples all three lines in the master clock domain. While the enable line is low, each rising edge of the serial clock shifts one data bit into the receiver, most significant bit first. The rising edge of the enable line closes the frame. Only the sixteen bits that arrived last before that edge count. Bit D0 is the last of them, and bit D15 came in fifteen bits earlier.

When a frame closes, the upper nibble of the word names the target register and bits D11..D2 carry a 10-bit setting. The block holds four settings: an amplifier gain code, a shutter code, a readout-rate select and a black-level clamp select. It raises a one-cycle write strobe for each command it accepts. Reset loads usable defaults, so the sensor runs without any command being sent. The host must keep the serial clock at no more than one quarter of the master clock rate.

Top module: `sercfg_rx`

## Requirements
- R1: After a synchronous active-low reset, `gain_code` equals parameter GAIN_DEF (default 10'h040), `shutter_code` equals SHUT_DEF (default 10'h000), `rate_dec` is 0 (full-rate readout) and `clamp_manual` is 0 (automatic clamp). `wr_stb` is 0.
- R2: A frame whose bits D15..D12 are 4'h0 loads bits D11..D2 into `gain_code`. D11 is the MSB. Bits D1 and D0 are ignored.
- R3: A frame whose select nibble is 4'hA loads bits D11..D2 into `shutter_code`.
- R4: A frame whose select nibble is 4'hC loads bit D2 into `rate_dec`: 0 selects full-rate readout and 1 selects decimated double-rate readout.
- R5: A frame whose select nibble is 4'hE loads bit D2 into `clamp_manual`: 0 selects automatic clamp and 1 selects manual (off).
- R6: When more than sixteen serial clocks occur in a frame, only the last sixteen bits before enable rises are decoded.
- R7: A frame with fewer than sixteen serial clocks before enable rises is discarded. No register changes and no strobe occurs.
- R8: A frame with any other select nibble changes no register and raises no strobe.
- R9: Each accepted frame raises `wr_stb` for exactly one master cycle. The strobe appears in the same cycle as the register update, on the third master clock edge after the edge that first samples enable high.
- R10: Serial clock edges while enable is high shift nothing and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_en | input | 1 | Frame enable, low during a frame, asynchronous |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, MSB first, asynchronous |
| gain_code | output | 10 | Stored amplifier gain code |
| shutter_code | output | 10 | Stored shutter code |
| rate_dec | output | 1 | 1 = decimated double-rate readout |
| clamp_manual | output | 1 | 1 = black-level clamp manual/off |
| wr_stb | output | 1 | One-cycle pulse per accepted command |

## Verification
The enable line goes through two synchronizer flops and an edge-detect flop before the commit register. Register outputs and the strobe therefore change three master edges after the first edge that sees enable high. The bench drives enable on a falling clock edge and then watches ten falling edges. It checks that exactly one strobe appears, at the third of them, for an accepted frame, and that none appears for a rejected frame. The bench compares register values only after this window has closed. Serial bits are held for four master cycles on each side of the serial clock edge, so the synchronized data is stable when the shift takes place.

// File: rtl/sercfg_pkg.sv
// Package: shared frame geometry and select codes for the serial
// configuration receiver. Field positions are fixed by the wire format.
package sercfg_pkg;

    localparam int FRAME_W = 16;
    localparam int SEL_W   = 4;
    localparam int SET_W   = 10;
    localparam int SEL_LSB = FRAME_W - SEL_W;   // 12
    localparam int SET_LSB = 2;                 // setting sits in D11..D2
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [SEL_W-1:0] {
        SEL_GAIN  = 4'h0,
        SEL_SHUT  = 4'hA,
        SEL_RATE  = 4'hC,
        SEL_CLAMP = 4'hE
    } sel_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [SET_W-1:0] setting;
        logic [1:0]       spare;
    } frame_t;

endpackage

// File: rtl/sercfg_sync.sv
// Module: sercfg_sync
// Brings the three serial lines into the master clock domain through a
// chain of STAGES flops each. It then produces the synchronized levels and
// single-cycle edge pulses. Assumes the serial clock is at most a quarter of
// the master clock rate, so no edge is missed.
module sercfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_dat,
    input  logic ser_en,
    output logic sclk_rise,
    output logic dat_s,
    output logic en_s,
    output logic en_rise,
    output logic en_fall
);
    localparam int NLINE = 3;
    // Idle values after reset: enable high, clock and data low.
    localparam logic [NLINE-1:0] IDLE = 3'b100;

    logic [NLINE-1:0] raw;
    logic [NLINE-1:0] synced;
    logic             sclk_q;
    logic             en_q;

    assign raw = {ser_en, ser_dat, ser_clk};

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        // Shift the raw line through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= {STAGES{IDLE[g]}};
            else        pipe <= {pipe[STAGES-2:0], raw[g]};
        end
        assign synced[g] = pipe[STAGES-1];
    end

    // Delayed copies of the synchronized clock and enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            en_q   <= 1'b1;
        end else begin
            sclk_q <= synced[0];
            en_q   <= synced[2];
        end
    end

    assign dat_s     = synced[1];
    assign en_s      = synced[2];
    assign sclk_rise = synced[0] & ~sclk_q;
    assign en_rise   = synced[2] & ~en_q;
    assign en_fall   = ~synced[2] & en_q;

endmodule

// File: rtl/sercfg_shift.sv
// Module: sercfg_shift
// Collects serial bits while enable is low and keeps the newest FRAME_W of
// them. A saturating counter records whether a full frame has arrived.
// Assumes enable falling marks the start of each frame.
module sercfg_shift
    import sercfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_rise,
    input  logic               dat_s,
    input  logic               en_s,
    input  logic               en_fall,
    output logic [FRAME_W-1:0] frame,
    output logic               frame_full
);
    logic [CNT_W-1:0] bit_cnt;
    logic             take_bit;

    assign take_bit = sclk_rise & ~en_s;

    // Shift a new bit in at the LSB on each serial clock edge inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)        frame <= '0;
        else if (take_bit) frame <= {frame[FRAME_W-2:0], dat_s};
    end

    // Count received bits, cleared at frame start, saturating at FRAME_W.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_cnt <= '0;
        else if (en_fall)
            bit_cnt <= '0;
        else if (take_bit && bit_cnt != CNT_W'(FRAME_W))
            bit_cnt <= bit_cnt + 1'b1;
    end

    assign frame_full = (bit_cnt == CNT_W'(FRAME_W));

endmodule

// File: rtl/sercfg_regs.sv
// Module: sercfg_regs
// Decodes a committed frame and updates the addressed setting register.
// Raises a one-cycle write strobe for each accepted command. Short frames
// and unknown selects are dropped. Defaults load on reset.
module sercfg_regs
    import sercfg_pkg::*;
#(
    parameter logic [SET_W-1:0] GAIN_DEF = 10'h040,
    parameter logic [SET_W-1:0] SHUT_DEF = 10'h000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic               frame_full,
    input  logic [FRAME_W-1:0] frame,
    output logic [SET_W-1:0]   gain_code,
    output logic [SET_W-1:0]   shutter_code,
    output logic               rate_dec,
    output logic               clamp_manual,
    output logic               wr_stb
);
    frame_t word;
    logic   hit_gain, hit_shut, hit_rate, hit_clamp;
    logic   accept;

    assign word = frame_t'(frame);

    // Decode the select nibble of a committed full frame.
    always_comb begin
        hit_gain  = 1'b0;
        hit_shut  = 1'b0;
        hit_rate  = 1'b0;
        hit_clamp = 1'b0;
        if (commit && frame_full) begin
            case (word.sel)
                SEL_GAIN:  hit_gain  = 1'b1;
                SEL_SHUT:  hit_shut  = 1'b1;
                SEL_RATE:  hit_rate  = 1'b1;
                SEL_CLAMP: hit_clamp = 1'b1;
                default:   ;
            endcase
        end
    end

    assign accept = hit_gain | hit_shut | hit_rate | hit_clamp;

    // Update the addressed register; load defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_code    <= GAIN_DEF;
            shutter_code <= SHUT_DEF;
            rate_dec     <= 1'b0;
            clamp_manual <= 1'b0;
        end else begin
            if (hit_gain)  gain_code    <= word.setting;
            if (hit_shut)  shutter_code <= word.setting;
            if (hit_rate)  rate_dec     <= word.setting[0];
            if (hit_clamp) clamp_manual <= word.setting[0];
        end
    end

    // One-cycle strobe aligned with the register update.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_stb <= 1'b0;
        else        wr_stb <= accept;
    end

endmodule

// File: rtl/sercfg_rx.sv
// Module: sercfg_rx (top)
// Three-wire serial configuration receiver: synchronizer, frame shifter and
// register decoder. Assumes the serial clock is at most a quarter of clk and
// that the reset is synchronous and active low.
module sercfg_rx
    import sercfg_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [SET_W-1:0]  GAIN_DEF    = 10'h040,
    parameter logic [SET_W-1:0]  SHUT_DEF    = 10'h000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_en,
    input  logic             ser_clk,
    input  logic             ser_dat,
    output logic [SET_W-1:0] gain_code,
    output logic [SET_W-1:0] shutter_code,
    output logic             rate_dec,
    output logic             clamp_manual,
    output logic             wr_stb
);
    logic               sclk_rise, dat_s, en_s, en_rise, en_fall;
    logic [FRAME_W-1:0] frame;
    logic               frame_full;

    sercfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .ser_en    (ser_en),
        .sclk_rise (sclk_rise),
        .dat_s     (dat_s),
        .en_s      (en_s),
        .en_rise   (en_rise),
        .en_fall   (en_fall)
    );

    sercfg_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_rise  (sclk_rise),
        .dat_s      (dat_s),
        .en_s       (en_s),
        .en_fall    (en_fall),
        .frame      (frame),
        .frame_full (frame_full)
    );

    sercfg_regs #(.GAIN_DEF(GAIN_DEF), .SHUT_DEF(SHUT_DEF)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit       (en_rise),
        .frame_full   (frame_full),
        .frame        (frame),
        .gain_code    (gain_code),
        .shutter_code (shutter_code),
        .rate_dec     (rate_dec),
        .clamp_manual (clamp_manual),
        .wr_stb       (wr_stb)
    );

endmodule

// File: rtl/sercfg_chk.sv
// Module: sercfg_chk
// Property checker bound into sercfg_rx. It watches the outputs together
// with the commit pulse and full-frame flag that pass between submodules.
module sercfg_chk
    import sercfg_pkg::*;
#(
    parameter logic [SET_W-1:0] GAIN_DEF = 10'h040,
    parameter logic [SET_W-1:0] SHUT_DEF = 10'h000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             commit,
    input logic             frame_full,
    input logic [SET_W-1:0] gain_code,
    input logic [SET_W-1:0] shutter_code,
    input logic             rate_dec,
    input logic             clamp_manual,
    input logic             wr_stb
);
    // R1
    reset_defaults_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (gain_code == GAIN_DEF && shutter_code == SHUT_DEF
                          && !rate_dec && !clamp_manual && !wr_stb));

    // R2
    gain_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_code) |-> wr_stb);

    // R3
    shut_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shutter_code) |-> wr_stb);

    // R4
    rate_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_dec) |-> wr_stb);

    // R5
    clamp_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clamp_manual) |-> wr_stb);

    // R7
    full_frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(commit && frame_full));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

endmodule

bind sercfg_rx sercfg_chk #(.GAIN_DEF(GAIN_DEF), .SHUT_DEF(SHUT_DEF)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit       (en_rise),
    .frame_full   (frame_full),
    .gain_code    (gain_code),
    .shutter_code (shutter_code),
    .rate_dec     (rate_dec),
    .clamp_manual (clamp_manual),
    .wr_stb       (wr_stb)
);

// File: tb/sim_sercfg_rx.sv
// Bench for sercfg_rx: directed corner cases plus seeded random frames,
// compared against a reference model kept in bench variables.
module sim_sercfg_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_en = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic [9:0] gain_code, shutter_code;
    logic       rate_dec, clamp_manual, wr_stb;

    int total = 0;
    int bad   = 0;

    logic [9:0] m_gain  = 10'h040;
    logic [9:0] m_shut  = 10'h000;
    logic       m_rate  = 1'b0;
    logic       m_clamp = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sercfg_rx u0 (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .gain_code(gain_code), .shutter_code(shutter_code),
        .rate_dec(rate_dec), .clamp_manual(clamp_manual), .wr_stb(wr_stb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // True when a 16-bit word names a known register.
    function automatic bit known_sel(input logic [15:0] w);
        return w[15:12] == 4'h0 || w[15:12] == 4'hA || w[15:12] == 4'hC || w[15:12] == 4'hE;
    endfunction

    // Update the reference model with an accepted word.
    task automatic model_apply(input logic [15:0] w);
        case (w[15:12])
            4'h0: m_gain  = w[11:2];
            4'hA: m_shut  = w[11:2];
            4'hC: m_rate  = w[2];
            4'hE: m_clamp = w[2];
            default: ;
        endcase
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_regs(input string req);
        check({req, " gain"},  32'(gain_code),    32'(m_gain));
        check({req, " shut"},  32'(shutter_code), 32'(m_shut));
        check({req, " rate"},  32'(rate_dec),     32'(m_rate));
        check({req, " clamp"}, 32'(clamp_manual), 32'(m_clamp));
    endtask

    // Send n bits (bits[n-1] first), then raise enable and check the strobe.
    task automatic send(input logic [31:0] bits, input int n, input string req);
        int stb_cnt, first;
        logic [15:0] last16;
        bit ok;
        @(negedge clk);
        ser_en = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
        wait_clk(4);
        ser_en = 1'b1;
        stb_cnt = 0;
        first = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (wr_stb) begin
                stb_cnt++;
                if (first == 0) first = k;
            end
        end
        last16 = bits[15:0];
        ok = (n >= 16) && known_sel(last16);
        if (ok) model_apply(last16);
        check({req, " R9 strobe count"}, 32'(stb_cnt), ok ? 32'd1 : 32'd0);
        if (ok) check({req, " R9 strobe cycle"}, 32'(first), 32'd3);
        check_regs(req);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int dummy;
        dummy = $urandom(32'd1234);
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset defaults
        check_regs("R1");
        check("R1 strobe", 32'(wr_stb), 32'd0);

        // R2 gain, D1/D0 ignored
        send(32'h0000_0A5B, 16, "R2");
        // R3 shutter
        send(32'h0000_A3FC, 16, "R3");
        // R4 rate select on then off
        send(32'h0000_C004, 16, "R4");
        check("R4 rate set", 32'(rate_dec), 32'd1);
        send(32'h0000_CFFB, 16, "R4");
        check("R4 rate cleared", 32'(rate_dec), 32'd0);
        // R5 clamp manual
        send(32'h0000_E004, 16, "R5");
        check("R5 clamp", 32'(clamp_manual), 32'd1);
        // R6 extra leading bits: the last 16 bits count
        send(32'h00AB_0C04, 24, "R6");
        check("R6 gain", 32'(gain_code), 32'h301);
        // R7 short frame discarded
        send(32'h0000_0FFC >> 1, 15, "R7");
        check("R7 gain kept", 32'(gain_code), 32'h301);
        // R8 unknown select
        send(32'h0000_5FFC, 16, "R8");
        // R10 serial clock toggles with enable high are ignored
        for (int i = 0; i < 20; i++) begin
            ser_dat = i[0];
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
            if (wr_stb) check("R10 no strobe", 32'd1, 32'd0);
        end
        wait_clk(6);
        check_regs("R10");

        // Random frames: mixed selects, lengths 14..20
        for (int r = 0; r < 40; r++) begin
            logic [31:0] b;
            int n;
            int pick;
            b = $urandom();
            pick = int'($urandom_range(0, 4));
            case (pick)
                0: b[15:12] = 4'h0;
                1: b[15:12] = 4'hA;
                2: b[15:12] = 4'hC;
                3: b[15:12] = 4'hE;
                default: ;
            endcase
            n = int'($urandom_range(14, 20));
            if (n < 16) b = b >> (16 - n);
            send(b & ((32'd1 << n) - 1), n, "R6 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule